// File: doc/BRIEF.md
# Load/Store Byte-Lane and Extension Unit

This unit sits between an integer pipeline and a 32-bit word-wide data memory. For each request it decodes a 6-bit memory opcode that sets the access size, the signedness and the direction. It adds the base register to the sign-extended 16-bit displacement to form the byte address. It then drives the memory's read enable, or its byte-lane write strobes and write data.

Stores place the low byte or low halfword of the source register on every lane that could hold it. A 4-bit strobe then picks the bytes that are actually written, with little-endian lane numbering (address bits [1:0] name the lane). Loads issue a read in the request cycle. The next cycle the unit takes the addressed byte or halfword out of the returned word, extends it to 32 bits and pulses a valid flag. A halfword or word access that does not sit on its natural boundary is flagged, and it reaches memory neither as a read nor as a write.

Top module: `lsu_lane_unit`

## Requirements
- R1: `mem_addr` equals `base + sign_extend(disp)` in the same cycle. This includes a zero base, where the address is the extended displacement alone, and a zero displacement, where the address is the base alone.
- R2: Opcodes: 0x20 signed byte load, 0x21 signed halfword load, 0x23 word load, 0x24 unsigned byte load, 0x25 unsigned halfword load, 0x28 byte store, 0x29 halfword store, 0x2B word store. A byte store sets only strobe bit `mem_addr[1:0]`. A halfword store sets 4'b0011 when `mem_addr[1]` is 0 and 4'b1100 when it is 1. A word store sets 4'b1111. Strobe bit n enables `mem_wdata[8n+7:8n]`.
- R3: Store data is replicated: a byte store drives `src[7:0]` on all four lanes, a halfword store drives `src[15:0]` on both halves, and a word store drives `src` unchanged.
- R4: Signed byte and halfword loads return the selected byte (lane `addr[1:0]`) or halfword (upper half when `addr[1]` is 1), sign-extended to 32 bits.
- R5: Unsigned byte and halfword loads return the same selection zero-extended to 32 bits.
- R6: A word load returns the full memory word unchanged.
- R7: A load asserts `mem_ren` in the request cycle. In the following cycle `load_valid` is high for exactly one cycle, with `load_data` valid.
- R8: A halfword access with address bit 0 set, or a word access with address bits [1:0] nonzero, raises `misalign` in the request cycle. It also drives strobes to 0, keeps `mem_ren` low and produces no `load_valid`. Byte accesses are never misaligned.
- R9: With `req_valid` low, or with an opcode outside the list in R2, the unit drives no strobe, no read and no `misalign`.
- R10: While reset is asserted, and in the first cycle after it, `load_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A memory operation is presented this cycle |
| opcode | input | 6 | Memory opcode selecting size, signedness, direction |
| base | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| store_src | input | 32 | Source register value for stores |
| mem_rdata | input | 32 | Word returned by memory one cycle after a read |
| mem_addr | output | 32 | Effective byte address |
| mem_ren | output | 1 | Memory read enable |
| mem_wstrb | output | 4 | Byte-lane write strobes |
| mem_wdata | output | 32 | Lane-replicated write data |
| misalign | output | 1 | Access not on its natural boundary |
| load_valid | output | 1 | Load result valid this cycle |
| load_data | output | 32 | Extended load result |

## Verification
Loads read one preloaded word whose byte lanes hold values with both high and low sign bits. Taking every lane and both halves under signed and unsigned opcodes therefore separates a wrong lane choice from a wrong extension. Byte, halfword and word stores go to offsets in every lane, and each is read back through word loads, so strobe placement and replication are confirmed by the memory contents. Misaligned halfword and word accesses, unknown opcodes and idle cycles are each followed by a read-back, which shows that nothing was written. The address tests use a negative displacement, a zero base, a zero displacement and a case that wraps past the top bit.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int XLEN   = 32;
  localparam int IMM_W  = 16;
  localparam int OP_W   = 6;
  localparam int LANES  = XLEN / 8;
  localparam int LIDX_W = $clog2(LANES);
  localparam int HALF_W = XLEN / 2;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic      is_load;
    logic      is_store;
    logic      is_signed;
    acc_size_e size;
  } acc_kind_t;
endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output acc_kind_t       kind
);
  always_comb begin
    kind = '{is_load: 1'b0, is_store: 1'b0, is_signed: 1'b0, size: ACC_WORD};
    unique case (opcode)
      6'h20: kind = '{is_load: 1'b1, is_store: 1'b0, is_signed: 1'b1, size: ACC_BYTE};
      6'h21: kind = '{is_load: 1'b1, is_store: 1'b0, is_signed: 1'b1, size: ACC_HALF};
      6'h23: kind = '{is_load: 1'b1, is_store: 1'b0, is_signed: 1'b0, size: ACC_WORD};
      6'h24: kind = '{is_load: 1'b1, is_store: 1'b0, is_signed: 1'b0, size: ACC_BYTE};
      6'h25: kind = '{is_load: 1'b1, is_store: 1'b0, is_signed: 1'b0, size: ACC_HALF};
      6'h28: kind = '{is_load: 1'b0, is_store: 1'b1, is_signed: 1'b0, size: ACC_BYTE};
      6'h29: kind = '{is_load: 1'b0, is_store: 1'b1, is_signed: 1'b0, size: ACC_HALF};
      6'h2b: kind = '{is_load: 1'b0, is_store: 1'b1, is_signed: 1'b0, size: ACC_WORD};
      default: ;
    endcase
  end
endmodule

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
(
  input  logic [XLEN-1:0]  base,
  input  logic [IMM_W-1:0] disp,
  input  acc_size_e        size,
  output logic [XLEN-1:0]  ea,
  output logic             unaligned
);
  logic [XLEN-1:0] disp_ext;

  always_comb begin
    disp_ext = {{(XLEN-IMM_W){disp[IMM_W-1]}}, disp};
    ea       = base + disp_ext;
    unique case (size)
      ACC_HALF: unaligned = ea[0];
      ACC_WORD: unaligned = |ea[LIDX_W-1:0];
      default:  unaligned = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_pkg::*;
(
  input  logic              active,
  input  acc_size_e         size,
  input  logic [LIDX_W-1:0] lane,
  input  logic [XLEN-1:0]   src,
  output logic [LANES-1:0]  wstrb,
  output logic [XLEN-1:0]   wdata
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [LIDX_W-1:0] LI = LIDX_W'(i);
    always_comb begin
      unique case (size)
        ACC_BYTE: begin
          wdata[8*i +: 8] = src[7:0];
          wstrb[i]        = active && (lane == LI);
        end
        ACC_HALF: begin
          wdata[8*i +: 8] = src[8*(i%2) +: 8];
          wstrb[i]        = active && (lane[LIDX_W-1] == LI[LIDX_W-1]);
        end
        default: begin
          wdata[8*i +: 8] = src[8*i +: 8];
          wstrb[i]        = active;
        end
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
(
  input  logic [XLEN-1:0]   rdata,
  input  acc_size_e         size,
  input  logic              is_signed,
  input  logic [LIDX_W-1:0] lane,
  output logic [XLEN-1:0]   data
);
  logic [7:0]        byte_sel;
  logic [HALF_W-1:0] half_sel;

  always_comb begin
    byte_sel = rdata[8*lane +: 8];
    half_sel = rdata[HALF_W*lane[LIDX_W-1] +: HALF_W];
    unique case (size)
      ACC_BYTE: data = {{(XLEN-8){is_signed & byte_sel[7]}}, byte_sel};
      ACC_HALF: data = {{(XLEN-HALF_W){is_signed & half_sel[HALF_W-1]}}, half_sel};
      default:  data = rdata;
    endcase
  end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [OP_W-1:0]   opcode,
  input  logic [XLEN-1:0]   base,
  input  logic [IMM_W-1:0]  disp,
  input  logic [XLEN-1:0]   store_src,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic [XLEN-1:0]   mem_addr,
  output logic              mem_ren,
  output logic [LANES-1:0]  mem_wstrb,
  output logic [XLEN-1:0]   mem_wdata,
  output logic              misalign,
  output logic              load_valid,
  output logic [XLEN-1:0]   load_data
);
  acc_kind_t         kind;
  logic              unaligned;
  logic              st_go;
  logic [XLEN-1:0]   ext_data;

  // load-return pipeline state
  logic              pend_q,  pend_d;
  acc_size_e         size_q,  size_d;
  logic              sgn_q,   sgn_d;
  logic [LIDX_W-1:0] lane_q,  lane_d;
  logic              cfg_en;

  lsu_decode u_dec (.opcode(opcode), .kind(kind));

  lsu_agen u_agen (
    .base(base), .disp(disp), .size(kind.size),
    .ea(mem_addr), .unaligned(unaligned)
  );

  always_comb begin
    misalign = req_valid && (kind.is_load || kind.is_store) && unaligned;
    mem_ren  = req_valid && kind.is_load && !unaligned;
    st_go    = req_valid && kind.is_store && !unaligned;
  end

  lsu_store_lane u_st (
    .active(st_go), .size(kind.size), .lane(mem_addr[LIDX_W-1:0]),
    .src(store_src), .wstrb(mem_wstrb), .wdata(mem_wdata)
  );

  always_comb begin
    pend_d = mem_ren;
    cfg_en = mem_ren;
    size_d = kind.size;
    sgn_d  = kind.is_signed;
    lane_d = mem_addr[LIDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= ACC_WORD;
      sgn_q  <= 1'b0;
      lane_q <= '0;
    end else if (cfg_en) begin
      size_q <= size_d;
      sgn_q  <= sgn_d;
      lane_q <= lane_d;
    end
  end

  lsu_load_extract u_ld (
    .rdata(mem_rdata), .size(size_q), .is_signed(sgn_q),
    .lane(lane_q), .data(ext_data)
  );

  always_comb begin
    load_valid = pend_q;
    load_data  = pend_q ? ext_data : '0;
  end
endmodule

// File: rtl/lsu_lane_unit_chk.sv
module lsu_lane_unit_chk
  import lsu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [OP_W-1:0]   opcode,
  input logic [LANES-1:0]  mem_wstrb,
  input logic              mem_ren,
  input logic              misalign,
  input logic              load_valid
);
  // R8: a flagged access reaches memory in no form
  p_misalign_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (mem_wstrb == '0) && !mem_ren);

  // R7: every read is followed by one result
  p_read_returns_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ren |=> load_valid);

  // R7: a result only follows a read
  p_valid_has_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |-> $past(mem_ren));

  // R2: strobes only for a store opcode
  p_strobe_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wstrb != '0) |-> req_valid && (opcode == 6'h28 || opcode == 6'h29 || opcode == 6'h2b));

  // R2: byte store writes at most one lane
  p_byte_one_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && opcode == 6'h28) |-> $countones(mem_wstrb) == 1);

  // R9: an idle cycle does nothing
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (mem_wstrb == '0) && !mem_ren && !misalign);

  // R10: no result straight out of reset
  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |=> !load_valid);
endmodule

bind lsu_lane_unit lsu_lane_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .opcode(opcode),
  .mem_wstrb(mem_wstrb), .mem_ren(mem_ren), .misalign(misalign),
  .load_valid(load_valid)
);

// File: tb/lsu_lane_unit_bench.sv
`timescale 1ns/1ps
module lsu_lane_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [5:0]  opcode;
  logic [31:0] base;
  logic [15:0] disp;
  logic [31:0] store_src;
  logic [31:0] mem_rdata;
  logic [31:0] mem_addr;
  logic        mem_ren;
  logic [3:0]  mem_wstrb;
  logic [31:0] mem_wdata;
  logic        misalign;
  logic        load_valid;
  logic [31:0] load_data;

  int n_chk  = 0;
  int n_fail = 0;

  logic [31:0] mem [0:63];

  always #2.5 clk = ~clk;

  lsu_lane_unit u_lsu_lane_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .opcode(opcode),
    .base(base), .disp(disp), .store_src(store_src), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_ren(mem_ren), .mem_wstrb(mem_wstrb),
    .mem_wdata(mem_wdata), .misalign(misalign), .load_valid(load_valid),
    .load_data(load_data)
  );

  always @(posedge clk) begin
    if (mem_ren) mem_rdata <= mem[mem_addr[7:2]];
    for (int b = 0; b < 4; b++)
      if (mem_wstrb[b]) mem[mem_addr[7:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // load: returns the result, the read enable and the flag of the request cycle,
  // and checks the valid pulse lasts exactly one cycle
  task automatic do_load(input logic [5:0] op, input logic [31:0] b, input logic [15:0] d,
                         output logic [31:0] data, output logic ren, output logic mis,
                         output logic vld);
    @(negedge clk);
    req_valid = 1'b1; opcode = op; base = b; disp = d;
    #1 ren = mem_ren; mis = misalign;
    @(negedge clk);
    req_valid = 1'b0;
    #1 vld = load_valid; data = load_data;
    @(negedge clk);
    #1 chk("R7 valid drops after one cycle", {31'd0, load_valid}, 32'd0);
  endtask

  task automatic do_store(input logic [5:0] op, input logic [31:0] b, input logic [15:0] d,
                          input logic [31:0] src, output logic [3:0] strb,
                          output logic [31:0] wd, output logic mis);
    @(negedge clk);
    req_valid = 1'b1; opcode = op; base = b; disp = d; store_src = src;
    #1 strb = mem_wstrb; wd = mem_wdata; mis = misalign;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic read_word(input logic [31:0] a, output logic [31:0] w);
    logic r, m, v;
    do_load(6'h23, a, 16'h0000, w, r, m, v);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_valid = 1'b0; opcode = 6'h00; base = '0; disp = '0; store_src = '0;
    repeat (3) @(negedge clk);
    chk("R10 load_valid in reset", {31'd0, load_valid}, 32'd0);
    chk("R9 strobe in reset", {28'd0, mem_wstrb}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 load_valid after reset", {31'd0, load_valid}, 32'd0);
  endtask

  task automatic t_address;
    @(negedge clk);
    base = 32'h0000_0020; disp = 16'hFFF0; #1 chk("R1 negative disp", mem_addr, 32'h0000_0010);
    base = 32'h0;         disp = 16'h0044; #1 chk("R1 zero base", mem_addr, 32'h0000_0044);
    base = 32'h0000_1000; disp = 16'h0000; #1 chk("R1 zero disp", mem_addr, 32'h0000_1000);
    base = 32'h8000_0000; disp = 16'h8000; #1 chk("R1 wrap", mem_addr, 32'h7FFF_8000);
  endtask

  task automatic t_load_signed;
    logic [31:0] d; logic r, m, v;
    do_load(6'h20, 32'h20, 16'hFFF1, d, r, m, v);
    chk("R7 ren on load", {31'd0, r}, 32'd1);
    chk("R7 valid next cycle", {31'd0, v}, 32'd1);
    chk("R4 lb lane1", d, 32'hFFFF_FFF1);
    do_load(6'h20, 32'h20, 16'hFFF2, d, r, m, v); chk("R4 lb lane2 positive", d, 32'h0000_007F);
    do_load(6'h21, 32'h20, 16'hFFF0, d, r, m, v); chk("R4 lh low half", d, 32'hFFFF_F13C);
    do_load(6'h21, 32'h20, 16'hFFF2, d, r, m, v); chk("R4 lh high half", d, 32'hFFFF_8A7F);
  endtask

  task automatic t_load_unsigned;
    logic [31:0] d; logic r, m, v;
    do_load(6'h24, 32'h10, 16'h0003, d, r, m, v); chk("R5 lbu lane3", d, 32'h0000_008A);
    do_load(6'h24, 32'h10, 16'h0000, d, r, m, v); chk("R5 lbu lane0", d, 32'h0000_003C);
    do_load(6'h25, 32'h10, 16'h0002, d, r, m, v); chk("R5 lhu high half", d, 32'h0000_8A7F);
    do_load(6'h25, 32'h10, 16'h0000, d, r, m, v); chk("R5 lhu low half", d, 32'h0000_F13C);
  endtask

  task automatic t_load_word;
    logic [31:0] d; logic r, m, v;
    do_load(6'h23, 32'h0, 16'h0010, d, r, m, v);
    chk("R6 lw word", d, 32'h8A7F_F13C);
    chk("R8 lw aligned not flagged", {31'd0, m}, 32'd0);
  endtask

  task automatic t_stores;
    logic [3:0] s; logic [31:0] w, rb; logic m;
    do_store(6'h28, 32'h20, 16'h0001, 32'h1234_56AB, s, w, m);
    chk("R2 sb strobe lane1", {28'd0, s}, 32'h2);
    chk("R3 sb replicated", w, 32'hABAB_ABAB);
    do_store(6'h28, 32'h23, 16'h0000, 32'h0000_00C5, s, w, m);
    chk("R2 sb strobe lane3", {28'd0, s}, 32'h8);
    chk("R8 byte never misaligned", {31'd0, m}, 32'd0);
    read_word(32'h20, rb); chk("R2 sb readback", rb, 32'hC500_AB00);
    do_store(6'h29, 32'h24, 16'h0002, 32'hCAFE_7788, s, w, m);
    chk("R2 sh strobe upper", {28'd0, s}, 32'hC);
    chk("R3 sh replicated", w, 32'h7788_7788);
    do_store(6'h29, 32'h24, 16'h0000, 32'h0000_1122, s, w, m);
    chk("R2 sh strobe lower", {28'd0, s}, 32'h3);
    read_word(32'h24, rb); chk("R3 sh readback", rb, 32'h7788_1122);
    do_store(6'h2b, 32'h30, 16'hFFF8, 32'h0BAD_F00D, s, w, m);
    chk("R2 sw strobe all", {28'd0, s}, 32'hF);
    chk("R3 sw data", w, 32'h0BAD_F00D);
    read_word(32'h28, rb); chk("R2 sw readback", rb, 32'h0BAD_F00D);
  endtask

  task automatic t_misalign;
    logic [31:0] d, w, rb; logic r, m, v; logic [3:0] s;
    do_load(6'h21, 32'h11, 16'h0000, d, r, m, v);
    chk("R8 lh odd flagged", {31'd0, m}, 32'd1);
    chk("R8 lh odd no read", {31'd0, r}, 32'd0);
    chk("R8 lh odd no valid", {31'd0, v}, 32'd0);
    do_load(6'h23, 32'h10, 16'h0002, d, r, m, v);
    chk("R8 lw offset2 flagged", {31'd0, m}, 32'd1);
    do_store(6'h2b, 32'h28, 16'h0001, 32'hFFFF_FFFF, s, w, m);
    chk("R8 sw flagged", {31'd0, m}, 32'd1);
    chk("R8 sw no strobe", {28'd0, s}, 32'd0);
    do_store(6'h29, 32'h28, 16'h0003, 32'hFFFF_FFFF, s, w, m);
    chk("R8 sh odd no strobe", {28'd0, s}, 32'd0);
    read_word(32'h28, rb); chk("R8 memory untouched", rb, 32'h0BAD_F00D);
  endtask

  task automatic t_idle;
    logic [31:0] d, w, rb; logic r, m, v; logic [3:0] s;
    do_store(6'h22, 32'h28, 16'h0000, 32'h0, s, w, m);
    chk("R9 unknown op no strobe", {28'd0, s}, 32'd0);
    chk("R9 unknown op no flag", {31'd0, m}, 32'd0);
    do_load(6'h27, 32'h28, 16'h0001, d, r, m, v);
    chk("R9 unknown op no read", {31'd0, r}, 32'd0);
    chk("R9 unknown op no valid", {31'd0, v}, 32'd0);
    @(negedge clk);
    req_valid = 1'b0; opcode = 6'h2b; base = 32'h28; store_src = 32'h0;
    #1 chk("R9 idle sw no strobe", {28'd0, mem_wstrb}, 32'd0);
    @(negedge clk);
    read_word(32'h28, rb); chk("R9 memory untouched", rb, 32'h0BAD_F00D);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    mem[4] = 32'h8A7F_F13C;
    mem_rdata = 32'h0;
    t_reset();
    t_address();
    t_load_signed();
    t_load_unsigned();
    t_load_word();
    t_stores();
    t_misalign();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule